// File: doc/BRIEF.md
# Sequential Multi-Column Cache Controller

This block is the lookup and fill controller of a small cache. It reaches set associativity while keeping all line storage in one array that is laid out and read like a direct-mapped store. A line address splits, from low to high, into a set field, a place-selector field and a tag. The physical slot of a line is its place number joined to its set number. The controller never reads the places of a set side by side. It looks at them one at a time.

Each access first looks at the place the set used most recently, so a repeated access finishes after a single lookup cycle. If that misses, the other places of the set are tried one per cycle, in rotating order starting just after the most-recent place. A place is skipped without a cycle when it holds no valid line, or when the place-selector bits stored with its line differ from those of the request. A read that misses everywhere fetches the line from the next memory level and installs it. The install goes to an empty place if there is one, otherwise to the place used least recently.

The CPU side issues one request at a time. Completion is a one-cycle `cpuDone` pulse that carries a hit flag, the read data and the number of lookup cycles spent. The associativity must be a power of two; 4 and 8 are intended.

Top module: `smc_cache`

## Requirements
- R1: After reset `cpuReady` is 1, `cpuDone` and `refillReq` are 0, and no place of any set holds a valid line, so the first read of any address misses after one lookup cycle.
- R2: The first lookup of every access goes to the most recently used place of the set. A hit there raises `cpuDone` one cycle after acceptance, with `cpuHit`=1 and `cpuProbes`=1.
- R3: After a first-lookup miss, unfiltered places are tried one per cycle in order MRU+1, MRU+2, … (modulo the associativity). A hit on the k-th lookup gives `cpuDone` k cycles after acceptance with `cpuProbes`=k.
- R4: A place that is invalid, or whose stored selector bits (address bits just above the set field) differ from the request's, costs no lookup cycle. `cpuProbes` never exceeds the associativity.
- R5: A read that misses every unfiltered place raises `refillReq` with `refillAddr` equal to the request address. Both hold steady until `refillGnt` is sampled high, and `refillReq` drops in the next cycle.
- R6: When `refillValid` is sampled high, the line is installed and the next cycle shows `cpuDone`=1, `cpuHit`=0 and `cpuRdata` equal to `refillData`. A later read of that address hits.
- R7: After a hit or an install, the place accessed becomes the set's most recently used place, so an immediate repeat access hits with `cpuProbes`=1.
- R8: An install uses the lowest-numbered invalid place of the set. If there is none, it uses the least recently used place, and the line there no longer hits.
- R9: `cpuReady` is low from the cycle after a request is accepted until the cycle of `cpuDone`. A `cpuValid` seen while it is low is ignored.
- R10: A write hit stores `cpuWdata` into the line, and a later read returns the new value. A write miss completes with `cpuHit`=0, never raises `refillReq`, and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU request present |
| cpuAddr | input | ADDR_W | Line address of the request |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Controller idle, request can be taken |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Completed access hit (valid with cpuDone) |
| cpuProbes | output | $clog2(WAYS+1) | Lookup cycles spent (valid with cpuDone) |
| cpuRdata | output | DATA_W | Read data (valid with cpuDone) |
| refillReq | output | 1 | Line fetch request to next level |
| refillAddr | output | ADDR_W | Address of the line to fetch |
| refillGnt | input | 1 | Next level accepts the fetch |
| refillValid | input | 1 | Fetched line present |
| refillData | input | DATA_W | Fetched line |

## Verification
The recency ages, the most-recent pointer and the stored selector bits never reach the ports directly. A fault in them shows up as a wrong `cpuProbes` value or a wrong completion latency on the very next access to the same set. A corrupted age shows up later, as the wrong line being evicted: an access that should hit raises `refillReq` instead, or an access that should miss returns old data. The directed sequence therefore drives one set through fill, reorder and two rounds of eviction. After each step it checks the lookup count, the latency and the data, so that each state error is caught within one or two accesses.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_ASK, ST_FILL} smcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new request
    logic touch;    // hit on current place: recency update, write data
    logic fill;     // install refilled line into victim place
    logic finish;   // register completion data
  } smcStrobe_t;
endpackage

// File: rtl/smc_datapath.sv
module smc_datapath import smc_pkg::*; #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 3,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int PLACE_W = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - SET_BITS - PLACE_W,
  localparam int SETS    = 1 << SET_BITS,
  localparam int LINES   = SETS * WAYS,
  localparam int LOC_W   = SET_BITS + PLACE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  smcStrobe_t         strobe,
  input  logic [PLACE_W-1:0] curPlace,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               cpuWrite,
  input  logic [DATA_W-1:0]  cpuWdata,
  input  logic [DATA_W-1:0]  refillData,
  output logic [PLACE_W-1:0] mruPlace,
  output logic [WAYS-1:0]    candMask,
  output logic               tagHit,
  output logic               reqWrite,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0]  reqWdata;
  logic [TAG_W-1:0]   tagMem   [LINES];
  logic [PLACE_W-1:0] selMem   [LINES];
  logic               validMem [LINES];
  logic [DATA_W-1:0]  dataMem  [LINES];
  logic [PLACE_W-1:0] ageMem   [LINES];
  logic [PLACE_W-1:0] mruMem   [SETS];

  logic [SET_BITS-1:0] reqSet;
  logic [PLACE_W-1:0]  reqSel, victim, touchPlace, touchAge;
  logic [TAG_W-1:0]    reqTag;
  logic [LOC_W-1:0]    curLoc;

  assign reqSet   = reqAddr[SET_BITS-1:0];
  assign reqSel   = reqAddr[SET_BITS +: PLACE_W];
  assign reqTag   = reqAddr[ADDR_W-1 -: TAG_W];
  assign curLoc   = {curPlace, reqSet};
  assign mruPlace = mruMem[reqSet];
  assign tagHit   = candMask[curPlace] && (tagMem[curLoc] == reqTag);

  for (genvar w = 0; w < WAYS; w++) begin : g_cand
    localparam logic [PLACE_W-1:0] PW = PLACE_W'(w);
    assign candMask[w] = validMem[{PW, reqSet}] && (selMem[{PW, reqSet}] == reqSel);
  end

  // victim: lowest invalid place, else the oldest one
  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageMem[{PLACE_W'(w), reqSet}] == PLACE_W'(WAYS - 1)) victim = PLACE_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validMem[{PLACE_W'(w), reqSet}]) victim = PLACE_W'(w);
  end

  assign touchPlace = strobe.fill ? victim : curPlace;
  assign touchAge   = ageMem[{touchPlace, reqSet}];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        validMem[i] <= 1'b0;
        ageMem[i]   <= PLACE_W'(i >> SET_BITS);
      end
      for (int s = 0; s < SETS; s++) mruMem[s] <= '0;
      reqAddr  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
      rdata    <= '0;
    end else begin
      if (strobe.capture) begin
        reqAddr  <= cpuAddr;
        reqWrite <= cpuWrite;
        reqWdata <= cpuWdata;
      end
      if (strobe.fill) begin
        validMem[{victim, reqSet}] <= 1'b1;
        tagMem[{victim, reqSet}]   <= reqTag;
        selMem[{victim, reqSet}]   <= reqSel;
        dataMem[{victim, reqSet}]  <= refillData;
      end
      if (strobe.touch && reqWrite) dataMem[curLoc] <= reqWdata;
      if (strobe.touch || strobe.fill) begin
        for (int w = 0; w < WAYS; w++) begin
          if (PLACE_W'(w) == touchPlace)
            ageMem[{PLACE_W'(w), reqSet}] <= '0;
          else if (ageMem[{PLACE_W'(w), reqSet}] < touchAge)
            ageMem[{PLACE_W'(w), reqSet}] <= ageMem[{PLACE_W'(w), reqSet}] + PLACE_W'(1);
        end
        mruMem[reqSet] <= touchPlace;
      end
      if (strobe.finish)
        rdata <= reqWrite ? reqWdata : (strobe.fill ? refillData : dataMem[curLoc]);
    end
  end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl import smc_pkg::*; #(
  parameter int WAYS     = 4,
  localparam int PLACE_W = $clog2(WAYS),
  localparam int PROBE_W = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuValid,
  input  logic               reqWrite,
  input  logic [PLACE_W-1:0] mruPlace,
  input  logic [WAYS-1:0]    candMask,
  input  logic               tagHit,
  input  logic               refillGnt,
  input  logic               refillValid,
  output smcStrobe_t         strobe,
  output logic [PLACE_W-1:0] curPlace,
  output logic               cpuReady,
  output logic               refillReq,
  output logic               cpuDone,
  output logic               cpuHit,
  output logic [PROBE_W-1:0] cpuProbes
);
  smcState_t          state;
  logic               firstProbe, found;
  logic [PLACE_W-1:0] nextPlace, pick;
  logic [WAYS-1:0]    tried, remaining;
  logic [PROBE_W-1:0] probeCnt;
  logic               inProbe;

  assign inProbe   = (state == ST_PROBE);
  assign curPlace  = firstProbe ? mruPlace : nextPlace;
  assign remaining = candMask & ~tried & ~(WAYS'(1) << curPlace);

  // next unfiltered place in rotating order after the MRU place
  always_comb begin
    logic [PLACE_W-1:0] p;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k < WAYS; k++) begin
      p = mruPlace + PLACE_W'(k);
      if (!found && remaining[p]) begin
        pick  = p;
        found = 1'b1;
      end
    end
  end

  assign cpuReady       = (state == ST_IDLE);
  assign refillReq      = (state == ST_ASK);
  assign strobe.capture = cpuReady && cpuValid;
  assign strobe.touch   = inProbe && tagHit;
  assign strobe.fill    = (state == ST_FILL) && refillValid;
  assign strobe.finish  = strobe.touch || strobe.fill ||
                          (inProbe && !tagHit && !found && reqWrite);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      firstProbe <= 1'b1;
      nextPlace  <= '0;
      tried      <= '0;
      probeCnt   <= '0;
      cpuDone    <= 1'b0;
      cpuHit     <= 1'b0;
      cpuProbes  <= '0;
    end else begin
      cpuDone <= strobe.finish;
      if (strobe.finish) begin
        cpuHit    <= strobe.touch;
        cpuProbes <= probeCnt;
      end
      unique case (state)
        ST_IDLE: if (strobe.capture) begin
          state      <= ST_PROBE;
          firstProbe <= 1'b1;
          tried      <= '0;
          probeCnt   <= PROBE_W'(1);
        end
        ST_PROBE: begin
          if (tagHit) state <= ST_IDLE;
          else if (found) begin
            nextPlace  <= pick;
            firstProbe <= 1'b0;
            tried      <= tried | (WAYS'(1) << curPlace);
            probeCnt   <= probeCnt + PROBE_W'(1);
          end else state <= reqWrite ? ST_IDLE : ST_ASK;
        end
        ST_ASK:  if (refillGnt) state <= ST_FILL;
        ST_FILL: if (refillValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smc_cache.sv
module smc_cache import smc_pkg::*; #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 3,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int PLACE_W = $clog2(WAYS),
  localparam int PROBE_W = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuValid,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               cpuWrite,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic               cpuReady,
  output logic               cpuDone,
  output logic               cpuHit,
  output logic [PROBE_W-1:0] cpuProbes,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               refillReq,
  output logic [ADDR_W-1:0]  refillAddr,
  input  logic               refillGnt,
  input  logic               refillValid,
  input  logic [DATA_W-1:0]  refillData
);
  smcStrobe_t         strobe;
  logic [PLACE_W-1:0] curPlace, mruPlace;
  logic [WAYS-1:0]    candMask;
  logic               tagHit, reqWrite;

  smc_ctrl #(.WAYS(WAYS)) i_ctrl (
    .clk, .rstN, .cpuValid, .reqWrite, .mruPlace, .candMask, .tagHit,
    .refillGnt, .refillValid, .strobe, .curPlace, .cpuReady, .refillReq,
    .cpuDone, .cpuHit, .cpuProbes
  );

  smc_datapath #(.WAYS(WAYS), .SET_BITS(SET_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk, .rstN, .strobe, .curPlace, .cpuAddr, .cpuWrite, .cpuWdata, .refillData,
    .mruPlace, .candMask, .tagHit, .reqWrite, .reqAddr(refillAddr), .rdata(cpuRdata)
  );
endmodule

// File: rtl/smc_checks.sv
module smc_checks #(
  parameter int WAYS    = 4,
  parameter int ADDR_W  = 12,
  parameter int PROBE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuValid,
  input logic               cpuReady,
  input logic               cpuDone,
  input logic [PROBE_W-1:0] cpuProbes,
  input logic               refillReq,
  input logic               refillGnt,
  input logic [ADDR_W-1:0]  refillAddr
);
  // R9: completion coincides with the return to idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReady);
  // R9: an accepted request makes the controller busy
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuReady) |=> !cpuReady);
  // R5: fetch request and its address hold until granted
  p_ask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !refillGnt) |=> (refillReq && $stable(refillAddr)));
  // R5: request drops after grant
  p_grant_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && refillGnt) |=> !refillReq);
  // R4: lookup count bounded by the associativity
  p_probe_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (cpuProbes >= PROBE_W'(1) && cpuProbes <= PROBE_W'(WAYS)));
  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  // R6: no fetch outstanding at completion
  p_done_noreq_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !refillReq);
endmodule

bind smc_cache smc_checks #(.WAYS(WAYS), .ADDR_W(ADDR_W), .PROBE_W(PROBE_W)) i_checks (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuReady(cpuReady), .cpuDone(cpuDone),
  .cpuProbes(cpuProbes), .refillReq(refillReq), .refillGnt(refillGnt), .refillAddr(refillAddr)
);

// File: tb/test_smc_cache.sv
module test_smc_cache;
  localparam int WAYS = 4, SET_BITS = 3, ADDR_W = 12, DATA_W = 32, PROBE_W = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0, refillGnt = 1'b0, refillValid = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0, refillData = '0;
  logic cpuReady, cpuDone, cpuHit, refillReq;
  logic [PROBE_W-1:0] cpuProbes;
  logic [DATA_W-1:0] cpuRdata;
  logic [ADDR_W-1:0] refillAddr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  smc_cache #(.WAYS(WAYS), .SET_BITS(SET_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_smc_cache (
    .clk, .rstN, .cpuValid, .cpuAddr, .cpuWrite, .cpuWdata, .cpuReady, .cpuDone, .cpuHit,
    .cpuProbes, .cpuRdata, .refillReq, .refillAddr, .refillGnt, .refillValid, .refillData
  );

  // address = {tag, selector, set}
  function automatic logic [ADDR_W-1:0] mk(input int tag, input int sel, input int set);
    return {7'(tag), 2'(sel), 3'(set)};
  endfunction
  function automatic logic [DATA_W-1:0] fd(input logic [ADDR_W-1:0] a);
    return 32'hA500_0000 | 32'(a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; refill=1 expects a line fetch served after gntDelay cycles
  task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input logic [DATA_W-1:0] wd,
                        input bit expHit, input int expProbes, input bit refill,
                        input logic [DATA_W-1:0] expData, input int gntDelay, input string req);
    int lat = 0;
    bit sawReq = 0;
    @(negedge clk);
    cpuValid = 1; cpuAddr = a; cpuWrite = wr; cpuWdata = wd;
    @(negedge clk);
    cpuValid = 0;
    check(!cpuReady, {req, " R9 busy after accept"}, 32'(cpuReady), 0);
    if (refill) begin
      while (!refillReq && lat < 20) begin @(negedge clk); lat++; end
      check(refillReq, {req, " R5 fetch raised"}, 32'(refillReq), 1);
      check(refillAddr == a, {req, " R5 fetch address"}, 32'(refillAddr), 32'(a));
      for (int i = 0; i < gntDelay; i++) begin
        cpuValid = 1; cpuAddr = a ^ 12'hFFF; cpuWrite = 0;  // ignored, R9
        @(negedge clk);
        check(refillReq && refillAddr == a, {req, " R5 fetch held"}, 32'(refillAddr), 32'(a));
        check(!cpuReady, {req, " R9 busy while fetching"}, 32'(cpuReady), 0);
      end
      cpuValid = 0; refillGnt = 1;
      @(negedge clk);
      refillGnt = 0;
      check(!refillReq, {req, " R5 fetch drops after grant"}, 32'(refillReq), 0);
      @(negedge clk);
      refillValid = 1; refillData = expData;
      @(negedge clk);
      refillValid = 0;
    end else begin
      while (!cpuDone && lat < 20) begin
        if (refillReq) sawReq = 1;
        @(negedge clk); lat++;
      end
      check(!sawReq, {req, " no fetch"}, 32'(sawReq), 0);
      check(lat == expProbes, {req, " latency"}, 32'(lat), 32'(expProbes));
    end
    check(cpuDone && cpuReady, {req, " done"}, 32'({cpuDone, cpuReady}), 32'h3);
    check(cpuHit == expHit, {req, " hit flag"}, 32'(cpuHit), 32'(expHit));
    check(32'(cpuProbes) == 32'(expProbes), {req, " probes"}, 32'(cpuProbes), 32'(expProbes));
    if (!wr) check(cpuRdata == expData, {req, " read data"}, cpuRdata, expData);
  endtask

  logic [ADDR_W-1:0] aA, aB, aC, aD, aE, aF;

  task automatic t_reset();
    check(cpuReady && !cpuDone && !refillReq, "R1 reset outputs",
          32'({cpuReady, cpuDone, refillReq}), 32'h4);
  endtask

  task automatic t_fill_set();
    access(aA, 0, 0, 0, 1, 1, fd(aA), 2, "R1 R6 first read misses");   // A -> place0
    access(aA, 0, 0, 1, 1, 0, fd(aA), 0, "R2 MRU hit");
    access(aB, 0, 0, 0, 1, 1, fd(aB), 0, "R8 invalid place used");      // B -> place1
    access(aC, 0, 0, 0, 1, 1, fd(aC), 1, "R4 selector mismatch skipped"); // C -> place2
    access(aD, 0, 0, 0, 3, 1, fd(aD), 0, "R4 invalid place skipped");    // D -> place3
  endtask

  task automatic t_seq_hits();
    access(aA, 0, 0, 1, 2, 0, fd(aA), 0, "R3 second lookup hit");
    access(aD, 0, 0, 1, 3, 0, fd(aD), 0, "R3 third lookup hit");
    access(aD, 0, 0, 1, 1, 0, fd(aD), 0, "R7 hit becomes MRU");
  endtask

  task automatic t_lru();
    access(aE, 0, 0, 0, 3, 1, fd(aE), 0, "R8 LRU victim B");
    access(aE, 0, 0, 1, 1, 0, fd(aE), 0, "R7 refill becomes MRU");
    access(aB, 0, 0, 0, 3, 1, fd(aB), 0, "R8 evicted line misses");     // evicts C
    access(aC, 0, 0, 0, 1, 1, fd(aC), 0, "R4 R8 no candidate left");     // evicts A
    access(aA, 0, 0, 0, 4, 1, fd(aA), 0, "R8 all candidates probed");
  endtask

  task automatic t_write();
    access(aF, 1, 32'h1111_2222, 0, 1, 0, 0, 0, "R10 write miss");
    access(aF, 0, 0, 0, 1, 1, fd(aF), 0, "R10 write miss not installed");
    access(aF, 1, 32'hCAFE_F00D, 1, 1, 0, 0, 0, "R10 write hit");
    access(aF, 0, 0, 1, 1, 0, 32'hCAFE_F00D, 0, "R10 write hit data");
  endtask

  initial begin
    aA = mk(1, 0, 0); aB = mk(2, 0, 0); aC = mk(3, 1, 0);
    aD = mk(4, 0, 0); aE = mk(5, 0, 0); aF = mk(6, 2, 1);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fill_set();
    t_seq_hits();
    t_lru();
    t_write();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule